// File: doc/BRIEF.md
# Raster LCD Sync and Timing Generator

This block produces the raster timing for a flat LCD panel: horizontal and vertical sync pulses, an active-video qualifier, the position of the current pixel inside the visible area, and one-cycle strobes that mark the first clock of a frame and the last clock of each line. It runs from the pixel clock. It does no pixel fetching and no clock division.

Software sets it up through a plain write port. There are three packed timing words and one control word. The timing words are staged and reach the counters only at a frame boundary, or at once while the controller is disabled. This lets software change a mode while the panel is scanning without tearing the frame. The control word acts on the next clock. It enables scanning and panel power, selects TFT or STN timing and single or dual panel scan, and encodes the colour depth, which the block decodes to a bit count for the pixel path.

Each line runs in this order: sync, back porch, active pixels, front porch. Each frame runs in the same order, counted in lines. In dual-panel mode the programmed line count covers one half of the display. The block also reports the matching line number in the lower half, which is scanned at the same time.

Top module: `lcd_raster_timing`

## Requirements
- R1: Writes with `wr_en` high store `wr_data` by `wr_addr`: 0 horizontal word, 1 vertical word, 2 polarity/line-clock word, 3 control word. Writes to addresses 4 to 7 change nothing.
- R2: Horizontal word: bits 15:8 = sync width−1, bits 31:24 = back porch−1, bits 23:16 = front porch−1, bits 7:2 = (active pixels/16)−1. The line length is the sum of the four spans.
- R3: Within a line, `hsync` is active for the first sync-width clocks, then the back porch follows, then the active pixels, then the front porch. `de` is active only for active pixels on active lines, and `pix_x` counts 0 upward across them (0 elsewhere).
- R4: Vertical word: bits 9:0 = lines per panel−1, bits 15:10 = vsync width−1, bits 23:16 = front porch lines and bits 31:24 = back porch lines, both unbiased (zero allowed). Line order is sync, back porch, active, front porch. `pix_y` gives the active line index while `de` is active (0 elsewhere).
- R5: With control bit 5 set (TFT), the active span per line is the pixel count from R2. With it clear (STN), the span is bits 25:16 of word 2 plus one.
- R6: In word 2, bit 11 inverts `vsync`, bit 12 inverts `hsync` and bit 14 inverts `de`. Bit 13 drives `pclk_inv`. With the bits clear, all three outputs are active high.
- R7: Timing words 0 to 2 written while enabled take effect only on the first clock of the next frame. While disabled they take effect on the clock after the write.
- R8: Control bit 0 enables scanning. While it is clear, the counters stay at zero, `sof`, `eol`, `pix_x`, `pix_y` and `lower_y` are 0, and `hsync`, `vsync` and `de` sit inactive with their inversion still applied.
- R9: `sof` is high for exactly the first clock of every frame, and `eol` for exactly the last clock of every line.
- R10: With control bit 7 set (dual panel), `lower_y` equals `pix_y` plus the lines-per-panel count while `de` is active. Otherwise it is 0.
- R11: Control bits 3:1 decode on `depth_bits` as 0→1, 1→2, 2→4, 3→8, 4→16, 5→24, and 6 or 7→0.
- R12: `panel_pwr` is high exactly when control bits 0 and 11 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register select |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per R6 |
| vsync | output | 1 | Vertical sync, polarity per R6 |
| de | output | 1 | Active-video qualifier, polarity per R6 |
| sof | output | 1 | First clock of a frame |
| eol | output | 1 | Last clock of a line |
| pix_x | output | XW (12) | Active pixel index |
| pix_y | output | YW (11) | Active line index |
| lower_y | output | YW (11) | Lower-half line index in dual-panel mode |
| pclk_inv | output | 1 | Pixel-clock edge select |
| panel_pwr | output | 1 | Panel power enable |
| depth_bits | output | 5 | Decoded bits per pixel |

## Verification
The embedded properties check these rules on every clock: counter stepping and wrap, the held-zero counters while disabled, that `sof` and `eol` never coincide, that a frame's last clock is followed by `sof`, that sync and active video are exclusive, and that the active timing words change only on a load. The ordering of spans within a line and a frame, the field decoding, the deferred takeover of a word written mid-frame, STN line length, dual-panel numbering and polarity can only be shown by the scenarios. There, a cycle model built from the requirements predicts every output on every clock.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

   localparam int WORD_W = 32;
   localparam int NUM_TW = 3;

   // register selects
   localparam int SEL_HORZ = 0;
   localparam int SEL_VERT = 1;
   localparam int SEL_POL  = 2;
   localparam int SEL_CTRL = 3;

   // polarity word bits
   localparam int B_INV_V  = 11;
   localparam int B_INV_H  = 12;
   localparam int B_PCLK   = 13;
   localparam int B_INV_DE = 14;

   // control word bits
   localparam int B_EN   = 0;
   localparam int B_TFT  = 5;
   localparam int B_DUAL = 7;
   localparam int B_PWR  = 11;

   typedef logic [WORD_W-1:0] word_t;

   function automatic logic [4:0] depth_decode(input logic [2:0] code);
      logic [4:0] r;
      case (code)
         3'd0:    r = 5'd1;
         3'd1:    r = 5'd2;
         3'd2:    r = 5'd4;
         3'd3:    r = 5'd8;
         3'd4:    r = 5'd16;
         3'd5:    r = 5'd24;
         default: r = 5'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
   import lcd_tim_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  word_t                   wr_data,
   input  logic                    load,
   output word_t [NUM_TW-1:0]      act_words,
   output word_t                   ctrl
);

   word_t [NUM_TW-1:0] stage_q;

   for (genvar gi = 0; gi < NUM_TW; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[gi] <= '0;
         else if (wr_en && (wr_addr == AW'(gi)))
            stage_q[gi] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_words[gi] <= '0;
         else if (load)
            act_words[gi] <= stage_q[gi];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= '0;
      else if (wr_en && (wr_addr == AW'(SEL_CTRL)))
         ctrl <= wr_data;
   end

   // R7
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_words));

endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] last,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   assign wrap = step && (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (step)
         cnt <= wrap ? '0 : cnt + W'(1);
   end

   // R3
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step && !wrap) |=> (cnt == $past(cnt) + W'(1)));

   // R9
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && wrap) |=> (cnt == '0));

endmodule

// File: rtl/lcd_phase_dec.sv
module lcd_phase_dec #(
   parameter int W = 12
) (
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] sync_len,
   input  logic [W-1:0] act_start,
   input  logic [W-1:0] act_len,
   output logic         in_sync,
   output logic         in_act,
   output logic [W-1:0] pos
);

   logic [W-1:0] rel;

   always_comb begin
      rel     = cnt - act_start;
      in_sync = cnt < sync_len;
      in_act  = (cnt >= act_start) && (rel < act_len);
      pos     = in_act ? rel : '0;
   end

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
   import lcd_tim_pkg::*;
#(
   parameter int AW = 3,
   parameter int XW = 12,
   parameter int YW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [31:0]   wr_data,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic          sof,
   output logic          eol,
   output logic [XW-1:0] pix_x,
   output logic [YW-1:0] pix_y,
   output logic [YW-1:0] lower_y,
   output logic          pclk_inv,
   output logic          panel_pwr,
   output logic [4:0]    depth_bits
);

   localparam int NLANE = 3;
   localparam logic [XW-1:0] X_ONE = XW'(1);
   localparam logic [YW-1:0] Y_ONE = YW'(1);

   if (AW < 3) begin : g_bad_aw
      $error("AW must reach four register selects");
   end
   if (XW < 11) begin : g_bad_xw
      $error("XW too narrow for the longest line");
   end
   if (YW < 11) begin : g_bad_yw
      $error("YW too narrow for the longest frame");
   end

   word_t [NUM_TW-1:0] act_w;
   word_t              ctrl;
   word_t              h_w, v_w, p_w;
   logic               en, load;

   // ---------------- registers ----------------
   lcd_cfg_regs #(.AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .load      (load),
      .act_words (act_w),
      .ctrl      (ctrl)
   );

   assign h_w = act_w[SEL_HORZ];
   assign v_w = act_w[SEL_VERT];
   assign p_w = act_w[SEL_POL];
   assign en  = ctrl[B_EN];

   // ---------------- field decode ----------------
   logic [XW-1:0] hs_len, h_bp, h_fp, h_pix, h_cpl, h_act, h_start, h_last;
   logic [YW-1:0] vs_len, v_bp, v_fp, v_lines, v_start, v_last;

   always_comb begin
      hs_len  = XW'(h_w[15:8])  + X_ONE;
      h_fp    = XW'(h_w[23:16]) + X_ONE;
      h_bp    = XW'(h_w[31:24]) + X_ONE;
      h_pix   = XW'({h_w[7:2], 4'b0000}) + XW'(16);
      h_cpl   = XW'(p_w[25:16]) + X_ONE;
      h_act   = ctrl[B_TFT] ? h_pix : h_cpl;
      h_start = hs_len + h_bp;
      h_last  = h_start + h_act + h_fp - X_ONE;

      vs_len  = YW'(v_w[15:10]) + Y_ONE;
      v_lines = YW'(v_w[9:0])   + Y_ONE;
      v_fp    = YW'(v_w[23:16]);
      v_bp    = YW'(v_w[31:24]);
      v_start = vs_len + v_bp;
      v_last  = v_start + v_lines + v_fp - Y_ONE;
   end

   // ---------------- counters ----------------
   logic [XW-1:0] h_cnt, h_pos;
   logic [YW-1:0] v_cnt, v_pos;
   logic          h_wrap, v_wrap;
   logic          h_in_sync, h_in_act, v_in_sync, v_in_act;

   lcd_axis_ctr #(.W(XW)) u_hctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .step  (en),
      .last  (h_last),
      .cnt   (h_cnt),
      .wrap  (h_wrap)
   );

   lcd_axis_ctr #(.W(YW)) u_vctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .step  (h_wrap),
      .last  (v_last),
      .cnt   (v_cnt),
      .wrap  (v_wrap)
   );

   assign load = !en || v_wrap;

   lcd_phase_dec #(.W(XW)) u_hdec (
      .cnt       (h_cnt),
      .sync_len  (hs_len),
      .act_start (h_start),
      .act_len   (h_act),
      .in_sync   (h_in_sync),
      .in_act    (h_in_act),
      .pos       (h_pos)
   );

   lcd_phase_dec #(.W(YW)) u_vdec (
      .cnt       (v_cnt),
      .sync_len  (vs_len),
      .act_start (v_start),
      .act_len   (v_lines),
      .in_sync   (v_in_sync),
      .in_act    (v_in_act),
      .pos       (v_pos)
   );

   // ---------------- output lanes ----------------
   logic [NLANE-1:0] lane_raw, lane_inv, lane_out;
   logic             de_raw;

   assign de_raw   = en && h_in_act && v_in_act;
   assign lane_raw = {de_raw, en && h_in_sync, en && v_in_sync};
   assign lane_inv = {p_w[B_INV_DE], p_w[B_INV_H], p_w[B_INV_V]};

   for (genvar gl = 0; gl < NLANE; gl++) begin : g_lane
      assign lane_out[gl] = lane_raw[gl] ^ lane_inv[gl];
   end

   assign vsync      = lane_out[0];
   assign hsync      = lane_out[1];
   assign de         = lane_out[2];
   assign sof        = en && (h_cnt == '0) && (v_cnt == '0);
   assign eol        = h_wrap;
   assign pix_x      = de_raw ? h_pos : '0;
   assign pix_y      = de_raw ? v_pos : '0;
   assign lower_y    = (de_raw && ctrl[B_DUAL]) ? (v_pos + v_lines) : '0;
   assign pclk_inv   = p_w[B_PCLK];
   assign panel_pwr  = en && ctrl[B_PWR];
   assign depth_bits = depth_decode(ctrl[3:1]);

   logic unused_bits;
   assign unused_bits = ^{h_w[1:0], p_w[10:0], p_w[15], p_w[31:26],
                          ctrl[4], ctrl[6], ctrl[10:8], ctrl[31:12]};

   // ---------------- properties ----------------
   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> (h_cnt == '0 && v_cnt == '0 && !sof && !eol));

   // R9
   sof_eol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> !eol);

   // R9
   frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_wrap |=> (sof || !en));

   // R3
   sync_act_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && h_in_sync) |-> !de_raw);

endmodule

// File: tb/test_lcd_raster_timing.sv
module test_lcd_raster_timing;

   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync, vsync, de, sof, eol, pclk_inv, panel_pwr;
   logic [11:0] pix_x;
   logic [10:0] pix_y, lower_y;
   logic [4:0]  depth_bits;

   lcd_raster_timing i_lcd_raster_timing (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hsync(hsync), .vsync(vsync), .de(de), .sof(sof), .eol(eol),
      .pix_x(pix_x), .pix_y(pix_y), .lower_y(lower_y), .pclk_inv(pclk_inv),
      .panel_pwr(panel_pwr), .depth_bits(depth_bits)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int hs, vs, de, sof, eol, x, y, ly, pinv, pwr, dep;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   // reference state
   logic [31:0] stg [3];
   logic [31:0] shd [3];
   logic [31:0] ctl;
   int          hc, vc;

   task automatic chk(input string tag, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic void geom(output int hs, output int hst, output int ha, output int hlast,
                                output int vs, output int vst, output int vl, output int vlast);
      int hb, hf, hp, cpl, vb, vf;
      hs  = int'(shd[0][15:8]) + 1;
      hf  = int'(shd[0][23:16]) + 1;
      hb  = int'(shd[0][31:24]) + 1;
      hp  = (int'(shd[0][7:2]) + 1) * 16;
      cpl = int'(shd[2][25:16]) + 1;
      ha  = ctl[5] ? hp : cpl;
      hst = hs + hb;
      hlast = hst + ha + hf - 1;
      vs  = int'(shd[1][15:10]) + 1;
      vl  = int'(shd[1][9:0]) + 1;
      vf  = int'(shd[1][23:16]);
      vb  = int'(shd[1][31:24]);
      vst = vs + vb;
      vlast = vst + vl + vf - 1;
   endfunction

   function automatic exp_t model_out();
      exp_t e;
      int hs, hst, ha, hlast, vs, vst, vl, vlast, dea;
      int dt [8] = '{1, 2, 4, 8, 16, 24, 0, 0};
      bit en;
      geom(hs, hst, ha, hlast, vs, vst, vl, vlast);
      en   = ctl[0];
      dea  = (en && hc >= hst && hc < hst + ha && vc >= vst && vc < vst + vl) ? 1 : 0;
      e.hs = int'((en && hc < hs) ^ shd[2][12]);
      e.vs = int'((en && vc < vs) ^ shd[2][11]);
      e.de = int'(dea[0] ^ shd[2][14]);
      e.sof = (en && hc == 0 && vc == 0) ? 1 : 0;
      e.eol = (en && hc >= hlast) ? 1 : 0;
      e.x  = dea ? hc - hst : 0;
      e.y  = dea ? vc - vst : 0;
      e.ly = (dea && ctl[7]) ? vc - vst + vl : 0;
      e.pinv = int'(shd[2][13]);
      e.pwr = int'(ctl[0] && ctl[11]);
      e.dep = dt[ctl[3:1]];
      return e;
   endfunction

   function automatic void model_edge(input logic w, input logic [2:0] a, input logic [31:0] d);
      int hs, hst, ha, hlast, vs, vst, vl, vlast;
      bit en, hw, vw;
      geom(hs, hst, ha, hlast, vs, vst, vl, vlast);
      en = ctl[0];
      hw = en && hc >= hlast;
      vw = hw && vc >= vlast;
      if (!en || vw) for (int i = 0; i < 3; i++) shd[i] = stg[i];
      if (w && a < 3) stg[a] = d;
      if (w && a == 3) ctl = d;
      if (!en) begin hc = 0; vc = 0; end
      else begin
         hc = hw ? 0 : hc + 1;
         if (hw) vc = vw ? 0 : vc + 1;
      end
   endfunction

   // driver: called just after a clock edge
   task automatic tick(input logic w, input logic [2:0] a, input logic [31:0] d);
      exp_q.push_back(model_out());
      wr_en = w; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      model_edge(w, a, d);
      wr_en = 0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 32'd0);
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R3 R6 hsync",     int'(hsync), e.hs);
            chk("R4 R6 vsync",     int'(vsync), e.vs);
            chk("R3 R5 R6 de",     int'(de), e.de);
            chk("R9 sof",          int'(sof), e.sof);
            chk("R2 R9 eol",       int'(eol), e.eol);
            chk("R2 R3 pix_x",     int'(pix_x), e.x);
            chk("R4 pix_y",        int'(pix_y), e.y);
            chk("R10 lower_y",     int'(lower_y), e.ly);
            chk("R6 pclk_inv",     int'(pclk_inv), e.pinv);
            chk("R12 panel_pwr",   int'(panel_pwr), e.pwr);
            chk("R11 depth_bits",  int'(depth_bits), e.dep);
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) begin stg[i] = '0; shd[i] = '0; end
      ctl = '0; hc = 0; vc = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: R8 idle outputs, R11 code 0 -> 1, R12 power off
      chk("R8 reset hsync", int'(hsync), 0);
      chk("R8 reset vsync", int'(vsync), 0);
      chk("R8 reset de", int'(de), 0);
      chk("R9 reset sof", int'(sof), 0);
      chk("R12 reset panel_pwr", int'(panel_pwr), 0);
      chk("R11 reset depth_bits", int'(depth_bits), 1);
      rst_n = 1;
      @(posedge clk); #1;

      // R1 R2 R4: 2 sync, 3 bp, 16 px, 2 fp; 1 vsync, 0 vbp, 3 lines, 1 vfp
      tick(1'b1, 3'd0, 32'h0201_0100);
      tick(1'b1, 3'd1, 32'h0001_0002);
      // enable, TFT, power, 16 bpp
      tick(1'b1, 3'd3, 32'h0000_0829);
      run(240);

      // R7: wider line written mid-frame, used from next frame
      run(30);
      tick(1'b1, 3'd0, 32'h0201_0104);
      run(300);

      // R6: all inversions and pclk edge, line clocks field = 19
      tick(1'b1, 3'd2, 32'h0013_7800);
      run(250);

      // R5: STN timing, 20 clocks per active line
      tick(1'b1, 3'd3, 32'h0000_0809);
      run(200);

      // R10: dual panel, 2 lines per half, 2 vsync, 2 vbp, 0 vfp
      tick(1'b1, 3'd1, 32'h0200_0401);
      tick(1'b1, 3'd3, 32'h0000_08A9);
      run(400);

      // R1: unmapped selects are ignored
      tick(1'b1, 3'd4, 32'hFFFF_FFFF);
      tick(1'b1, 3'd5, 32'hFFFF_FFFF);
      tick(1'b1, 3'd7, 32'h0000_0000);
      run(100);

      // R8 R11: disable, depth code 6 -> 0, inversions still shown
      tick(1'b1, 3'd3, 32'h0000_000C);
      run(40);

      while (exp_q.size() > 0) @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule